// File: doc/BRIEF.md
# Serial NOR Command Shifter

This block issues arbitrary short command sequences to a serial NOR flash. Software fills a stack of six outgoing byte registers, sets how many bits to clock, and then writes a command code into the command register. The engine lowers chip select and clocks the bits out MSB first in SPI mode 0, starting with the top byte. It samples the returning bits into a small readback window and then releases the bus. The command register keeps the code that was written until the transfer is over, then reads zero. Software therefore polls that same register to wait for completion.

There are two shortcut codes besides the generic transfer. One reads the flash status register and places the returned byte in a dedicated result register. The other writes the flash status register using the top outgoing byte. No command is taken until a key value has been written to the lock register. SCK is the system clock divided by an even parameter.

Top module: `nor_cmd_shifter`

## Requirements
- R1: A command write is ignored unless the lock register last received the key 0x30. Any other value written to the lock register locks the block again. The lock register reads back 1 when unlocked and 0 when locked.
- R2: A write to the command register (address 0) with a legal code starts a transfer. The register reads back the written code while the transfer runs and reads 0 once it completes.
- R3: Code 0x04 clocks exactly the programmed bit count. The bits come from outgoing byte 5 (address 9) down to byte 0 (address 4), each byte MSB first.
- R4: A bit count of 0 completes the command without asserting chip select. A bit count above 48 is treated as 48.
- R5: SCK is low whenever chip select is high and at the moment chip select falls. MOSI changes only after SCK falls. MISO is sampled as SCK rises.
- R6: Chip select rises exactly one SCK period (SCK_DIV clocks) after the last falling SCK edge.
- R7: Received bits shift into a 24-bit window, with the newest bit in bit 0. Readback byte k (address 10+k) shows window bits 8k+7..8k. After a 32-bit transfer, byte 2 holds the second received byte and byte 0 holds the fourth.
- R8: Code 0x02 sends opcode 0x05 followed by 8 idle bits, 16 SCK cycles in total. The second received byte is stored in the status-result register (address 2).
- R9: Code 0x20 sends opcode 0x01 followed by outgoing byte 5, 16 SCK cycles in total.
- R10: A command write made while a command is in progress is ignored. The running transfer and the stored status result are left unchanged.
- R11: A command code other than 0x02, 0x04 or 0x20 is ignored. It starts nothing and the command register stays 0.
- R12: The SCK period is SCK_DIV system clocks, with SCK_DIV/2 clocks high and SCK_DIV/2 clocks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0 command, 1 bit count, 2 status result, 3 lock, 4-9 outgoing bytes 0-5, 10-12 readback bytes 0-2 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The assertions check on every cycle the things that hold at any instant. SCK stays inside the chip-select frame and is low when the frame opens and closes. A locked block never opens a frame. The command register stays constant while a command runs, is nonzero for the whole frame, and clears right after completion. Other behaviour needs the bench's flash model to bring bits back and compare them. This covers the exact bits and their order on MOSI, the mapping of received bits into the readback and status registers, the clamping of the bit count, and the measured SCK period and chip-select tail.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int OUT_BYTES = 6;
  localparam int RX_BYTES  = 3;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_LOCK = 4'd3;
  localparam logic [ADDR_W-1:0] A_OUT0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_RB0  = A_OUT0 + ADDR_W'(OUT_BYTES);

  localparam logic [7:0] CMD_PRG    = 8'h04;
  localparam logic [7:0] CMD_RDST   = 8'h02;
  localparam logic [7:0] CMD_WRST   = 8'h20;
  localparam logic [7:0] UNLOCK_KEY = 8'h30;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_WRSR   = 8'h01;

  typedef enum logic [1:0] {OP_PRG, OP_RDST, OP_WRST} op_e;
endpackage

// File: rtl/nor_cmd_regs.sv
module nor_cmd_regs
  import nor_cmd_pkg::*;
#(
  parameter int OUT_B = OUT_BYTES,
  parameter int RX_B  = RX_BYTES,
  parameter int CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic                done_i,
  input  logic [8*RX_B-1:0]   rx_i,
  output logic                start_o,
  output op_e                 op_o,
  output logic [8*OUT_B-1:0]  tx_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [7:0]          cmd_o,
  output logic                unlocked_o
);
  logic [7:0]       cmd_q, stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unlock_q;
  logic [7:0]       out_q [OUT_B];
  logic             legal;

  assign legal   = (wdata_i == CMD_PRG) || (wdata_i == CMD_RDST) || (wdata_i == CMD_WRST);
  assign start_o = wr_i && (addr_i == A_CMD) && unlock_q && (cmd_q == 8'h00) && legal;

  always_comb begin
    unique case (wdata_i)
      CMD_RDST: op_o = OP_RDST;
      CMD_WRST: op_o = OP_WRST;
      default:  op_o = OP_PRG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      stat_q   <= '0;
      cnt_q    <= '0;
      unlock_q <= 1'b0;
    end else begin
      if (done_i) begin
        cmd_q <= '0;
        if (cmd_q == CMD_RDST) stat_q <= rx_i[7:0];
      end else if (start_o) begin
        cmd_q <= wdata_i;
      end
      if (wr_i && addr_i == A_CNT)  cnt_q    <= CNT_W'(wdata_i);
      if (wr_i && addr_i == A_LOCK) unlock_q <= (wdata_i == UNLOCK_KEY);
    end
  end

  for (genvar g = 0; g < OUT_B; g++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      out_q[g] <= '0;
      else if (wr_i && addr_i == A_OUT0 + ADDR_W'(g))   out_q[g] <= wdata_i;
    end
    assign tx_o[8*g +: 8] = out_q[g];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD:   rdata_o = cmd_q;
      A_CNT:   rdata_o = 8'(cnt_q);
      A_STAT:  rdata_o = stat_q;
      A_LOCK:  rdata_o = {7'b0, unlock_q};
      default: begin
        for (int i = 0; i < OUT_B; i++)
          if (addr_i == A_OUT0 + ADDR_W'(i)) rdata_o = out_q[i];
        for (int i = 0; i < RX_B; i++)
          if (addr_i == A_RB0 + ADDR_W'(i)) rdata_o = rx_i[8*i +: 8];
      end
    endcase
  end

  assign cnt_o      = cnt_q;
  assign cmd_o      = cmd_q;
  assign unlocked_o = unlock_q;
endmodule

// File: rtl/nor_cmd_timer.sv
module nor_cmd_timer #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic wrap_half_i,
  output logic half_o,
  output logic full_o
);
  localparam int HALF = DIV / 2;
  localparam int DC_W = $clog2(DIV) + 1;

  logic [DC_W-1:0] cnt_q;

  assign half_o = (cnt_q == DC_W'(HALF - 1));
  assign full_o = (cnt_q == DC_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (en_i) begin
      if (wrap_half_i && half_o)    cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int OUT_B = OUT_BYTES,
  parameter int RX_B  = RX_BYTES,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  op_e                op_i,
  input  logic [8*OUT_B-1:0] tx_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               miso_i,
  output logic               cs_no,
  output logic               sck_o,
  output logic               mosi_o,
  output logic [8*RX_B-1:0]  rx_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam int TX_W = 8 * OUT_B;
  localparam int RX_W = 8 * RX_B;
  localparam int N_W  = $clog2(TX_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL} st_e;

  st_e             st_q;
  logic [TX_W-1:0] tx_q, tx_sel;
  logic [RX_W-1:0] rx_q;
  logic [N_W-1:0]  left_q, n_sel;
  logic            cs_q, sck_q, done_q;
  logic            half, full, last_fall;

  always_comb begin
    unique case (op_i)
      OP_RDST: begin
        tx_sel = {OPC_RDSR, {(TX_W-8){1'b0}}};
        n_sel  = N_W'(16);
      end
      OP_WRST: begin
        tx_sel = {OPC_WRSR, tx_i[TX_W-1 -: 8], {(TX_W-16){1'b0}}};
        n_sel  = N_W'(16);
      end
      default: begin
        tx_sel = tx_i;
        n_sel  = (int'(cnt_i) > TX_W) ? N_W'(TX_W) : N_W'(cnt_i);
      end
    endcase
  end

  assign last_fall = (st_q == S_SHIFT) && half && sck_q && (left_q == N_W'(1));

  nor_cmd_timer #(.DIV(DIV)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       ((st_q == S_IDLE) || last_fall),
    .en_i        (st_q != S_IDLE),
    .wrap_half_i (st_q == S_SHIFT),
    .half_o      (half),
    .full_o      (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          if (n_sel == '0) begin
            done_q <= 1'b1;
          end else begin
            st_q   <= S_SHIFT;
            cs_q   <= 1'b0;
            tx_q   <= tx_sel;
            left_q <= n_sel;
            rx_q   <= '0;
          end
        end
        S_SHIFT: if (half) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[RX_W-2:0], miso_i};
          end else begin
            sck_q  <= 1'b0;
            tx_q   <= tx_q << 1;
            left_q <= left_q - 1'b1;
            if (left_q == N_W'(1)) st_q <= S_TAIL;
          end
        end
        S_TAIL: if (full) begin
          cs_q   <= 1'b1;
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_q;
  assign sck_o  = sck_q;
  assign mosi_o = ~cs_q & tx_q[TX_W-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;
  assign busy_o = (st_q != S_IDLE);
endmodule

// File: rtl/nor_cmd_shifter.sv
module nor_cmd_shifter
  import nor_cmd_pkg::*;
#(
  parameter int SCK_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  logic                   start_w, done_w, busy_w, unlocked_w;
  op_e                    op_w;
  logic [8*OUT_BYTES-1:0] tx_w;
  logic [8*RX_BYTES-1:0]  rx_w;
  logic [CNT_W-1:0]       cnt_w;
  logic [7:0]             cmd_w;

  nor_cmd_regs #(.OUT_B(OUT_BYTES), .RX_B(RX_BYTES), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .done_i     (done_w),
    .rx_i       (rx_w),
    .start_o    (start_w),
    .op_o       (op_w),
    .tx_o       (tx_w),
    .cnt_o      (cnt_w),
    .cmd_o      (cmd_w),
    .unlocked_o (unlocked_w)
  );

  nor_cmd_engine #(.DIV(SCK_DIV), .OUT_B(OUT_BYTES), .RX_B(RX_BYTES), .CNT_W(CNT_W)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .op_i    (op_w),
    .tx_i    (tx_w),
    .cnt_i   (cnt_w),
    .miso_i  (spi_miso_i),
    .cs_no   (spi_cs_no),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .rx_o    (rx_w),
    .done_o  (done_w),
    .busy_o  (busy_w)
  );
endmodule

// File: rtl/nor_cmd_shifter_chk.sv
module nor_cmd_shifter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n,
  input logic       sck,
  input logic [7:0] cmd,
  input logic       unlocked,
  input logic       done,
  input logic       busy
);
  AST_SCK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck |-> !cs_n); // R5
  AST_CS_FALL_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n) |-> !sck); // R5
  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n) |-> (!sck && !$past(sck))); // R6
  AST_LOCKED_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && cs_n && !busy) |=> cs_n); // R1
  AST_DONE_CLEARS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (cmd == 8'h00)); // R2
  AST_FRAME_HAS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n |-> (cmd != 8'h00)); // R2
  AST_BUSY_HOLDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd != 8'h00) && !done) |=> $stable(cmd)); // R10
endmodule

bind nor_cmd_shifter nor_cmd_shifter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_n     (spi_cs_no),
  .sck      (spi_sck_o),
  .cmd      (cmd_w),
  .unlocked (unlocked_w),
  .done     (done_w),
  .busy     (busy_w)
);

// File: tb/nor_cmd_shifter_tb_top.sv
module nor_cmd_shifter_tb_top;
  import nor_cmd_pkg::*;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cs_n, sck, mosi;
  logic       miso = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_shifter #(.SCK_DIV(DIV)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr_en),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .spi_cs_no   (cs_n),
    .spi_sck_o   (sck),
    .spi_mosi_o  (mosi),
    .spi_miso_i  (miso)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model and timing monitor
  int cyc = 0, sck_cnt = 0, bit_idx = 0, cs_falls = 0;
  int last_fall = 0, last_rise = 0, period = 0, gap = 0;
  bit sck_low_at_fall = 1;
  logic p_sck = 1'b0, p_cs = 1'b1;
  logic [63:0] mosi_log = '0, resp = '0;

  always @(negedge clk) begin
    cyc++;
    if (p_cs && !cs_n) begin
      cs_falls++;
      mosi_log = '0;
      sck_cnt = 0;
      bit_idx = 0;
      period = 0;
      sck_low_at_fall = !sck;
      miso = resp[63];
    end
    if (!p_sck && sck) begin
      mosi_log = {mosi_log[62:0], mosi};
      sck_cnt++;
      if (sck_cnt == 2) period = cyc - last_rise;
      last_rise = cyc;
    end
    if (p_sck && !sck) begin
      last_fall = cyc;
      bit_idx++;
      if (bit_idx < 64) miso = resp[63-bit_idx];
    end
    if (!p_cs && cs_n) gap = cyc - last_fall;
    p_sck = sck;
    p_cs = cs_n;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int k = 0; k < 4000; k++) begin
      rd(A_CMD, d);
      if (d == 8'h00) break;
    end
  endtask

  task automatic run(input logic [7:0] code);
    wr(A_CMD, code);
    wait_idle();
  endtask

  typedef struct packed {
    logic [7:0]  cnt;
    logic [47:0] outv;
    logic [63:0] rsp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd8,  48'h06_0000000000, 64'h0},
    '{8'd32, 48'h9F_0000000000, 64'h00EF4018_00000000},
    '{8'd24, 48'h03_1234AB_0000, 64'hFFFF00C3_5A000000},
    '{8'd48, 48'hDEADBEEF0155,   64'h01234567_89ABCDEF}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int falls0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R5 reset cs", {63'b0, cs_n}, 64'd1);
    check("R5 reset sck", {63'b0, sck}, 64'd0);
    rd(A_CMD, d);  check("R2 reset cmd", {56'b0, d}, 64'h0);
    rd(A_LOCK, d); check("R1 reset lock", {56'b0, d}, 64'h0);

    // locked: command ignored
    wr(A_CNT, 8'd8);
    wr(A_CMD, CMD_PRG);
    repeat (20) @(negedge clk);
    check("R1 locked no frame", 64'(cs_falls), 64'd0);
    rd(A_CMD, d); check("R1 locked cmd", {56'b0, d}, 64'h0);

    wr(A_LOCK, UNLOCK_KEY);
    rd(A_LOCK, d); check("R1 unlocked", {56'b0, d}, 64'h1);

    // vector table: generic transfers
    for (int i = 0; i < 4; i++) begin
      int n;
      logic [63:0] exp_mosi, exp_rx;
      n = int'(VECS[i].cnt);
      for (int b = 0; b < 6; b++) wr(A_OUT0 + 4'(b), VECS[i].outv[8*b +: 8]);
      wr(A_CNT, VECS[i].cnt);
      resp = VECS[i].rsp;
      run(CMD_PRG);
      exp_mosi = 64'(VECS[i].outv) >> (48 - n);
      exp_rx   = (VECS[i].rsp >> (64 - n)) & 64'hFFFFFF;
      check("R3 mosi bits", mosi_log, exp_mosi);
      check("R3 sck count", 64'(sck_cnt), 64'(n));
      for (int b = 0; b < 3; b++) begin
        rd(A_RB0 + 4'(b), d);
        check("R7 readback", {56'b0, d}, (exp_rx >> (8*b)) & 64'hFF);
      end
      check("R12 sck period", 64'(period), 64'(DIV));
      check("R6 cs tail", 64'(gap), 64'(DIV));
      check("R5 sck low at cs fall", {63'b0, sck_low_at_fall}, 64'd1);
    end

    // busy readback and write while busy
    wr(A_CNT, 8'd32);
    resp = 64'h00A5_0000_0000_0000;
    wr(A_CMD, CMD_PRG);
    rd(A_CMD, d); check("R2 busy code", {56'b0, d}, 64'h04);
    wr(A_CMD, CMD_RDST);
    wait_idle();
    check("R10 running transfer kept", 64'(sck_cnt), 64'd32);
    rd(A_STAT, d); check("R10 status untouched", {56'b0, d}, 64'h0);
    rd(A_CMD, d);  check("R2 cleared", {56'b0, d}, 64'h0);

    // illegal code
    falls0 = cs_falls;
    wr(A_CMD, 8'h08);
    repeat (20) @(negedge clk);
    check("R11 no frame", 64'(cs_falls), 64'(falls0));
    rd(A_CMD, d); check("R11 cmd zero", {56'b0, d}, 64'h0);

    // zero count
    wr(A_CNT, 8'd0);
    wr(A_CMD, CMD_PRG);
    repeat (20) @(negedge clk);
    check("R4 zero count no frame", 64'(cs_falls), 64'(falls0));
    rd(A_CMD, d); check("R4 zero count done", {56'b0, d}, 64'h0);

    // count clamp (outgoing bytes still hold last vector)
    wr(A_CNT, 8'd60);
    run(CMD_PRG);
    check("R4 clamp count", 64'(sck_cnt), 64'd48);
    check("R4 clamp bits", mosi_log, 64'hDEADBEEF0155);

    // status read
    resp = 64'h00A5_0000_0000_0000;
    run(CMD_RDST);
    check("R8 opcode", mosi_log, 64'h0500);
    check("R8 sck count", 64'(sck_cnt), 64'd16);
    rd(A_STAT, d); check("R8 status result", {56'b0, d}, 64'hA5);

    // status write
    wr(A_OUT0 + 4'd5, 8'h9C);
    run(CMD_WRST);
    check("R9 bits", mosi_log, 64'h019C);
    check("R9 sck count", 64'(sck_cnt), 64'd16);

    // relock
    wr(A_LOCK, 8'h31);
    falls0 = cs_falls;
    wr(A_CNT, 8'd8);
    wr(A_CMD, CMD_PRG);
    repeat (20) @(negedge clk);
    check("R1 relocked no frame", 64'(cs_falls), 64'(falls0));
    rd(A_LOCK, d); check("R1 relocked", {56'b0, d}, 64'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule